// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Model

This block models one general-purpose microcontroller I/O port of parameterised width. Each bit keeps an output latch that the CPU writes. The latch value controls a pull-down on the pin. A bit whose latch holds 1 releases the pin, so an external source can drive it and the bit can act as an input. A bit whose latch holds 0 pulls the pin to ground, and that pin reads 0 whatever drives it from outside.

The CPU side has a write strobe with data and two read strobes that share one registered 8-bit-wide (parameterised) return bus. One strobe samples the resolved pin levels. The other returns the latch contents and serves read-modify-write sequences. A per-bit alternate-function output is combined with the latch, so an alternate function can pull a pin low only while its latch holds 1.

A parameter selects the pin style. In the pulled-up style a released pin with no external driver reads high. In the open-drain style there is no internal pull-up. A released, undriven pin floats, and the block flags it on a per-bit output. The value it returns for a floating bit carries no meaning.

Top module: `qbp_port`

## Requirements
- R1: While reset is asserted and after it, until the first write, every latch bit is 1, `pull_low` is all zeros and `rd_data` is all zeros.
- R2: A write with `wr_en` loads `wr_data` into the latch at the next clock edge and never changes `rd_data`. Without `wr_en` the latch holds.
- R3: `rd_pin_en` alone captures the resolved pin levels into `rd_data` at the next clock edge, so they are visible one cycle after the strobe.
- R4: A bit whose latch is 0 has `pull_low` set, and its pin reads 0 even when the external driver drives it high.
- R5: In the pulled-up style, a released bit reads `ext_val` where `ext_en` is 1 and reads 1 where `ext_en` is 0. `pin_float` is always 0.
- R6: In the open-drain style, a released bit with `ext_en` 0 has `pin_float` set. A released bit with `ext_en` 1 reads `ext_val`. A pulled-low bit never floats.
- R7: `rd_latch_en` captures the latch contents into `rd_data` at the next clock edge. The pin levels play no part in this.
- R8: `pull_low` for each bit equals the inverse of (latch bit AND `alt_out` bit). With `alt_out` all ones, the port behaves as latch only.
- R9: When both read strobes are high in one cycle, the latch read wins.
- R10: A pin read in the same cycle as a write sees the latch value from before the write.
- R11: With neither read strobe high, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Data for the latch |
| rd_pin_en | input | 1 | Strobe that samples the pin levels |
| rd_latch_en | input | 1 | Strobe that samples the latch contents |
| rd_data | output | WIDTH | Registered read return |
| alt_out | input | WIDTH | Alternate-function output per bit (tie high when unused) |
| ext_en | input | WIDTH | External driver active per bit |
| ext_val | input | WIDTH | Level driven by the external driver |
| pull_low | output | WIDTH | Pull-down enable per bit |
| pin_float | output | WIDTH | Released pin with no driver (open-drain style only) |

## Verification
`pull_low` and `pin_float` are combinational from the latch. They are therefore due in the same cycle the latch changes, one edge after the write strobe. `rd_data` is due one edge after a read strobe. The bench drives every strobe on a falling edge and samples all outputs on the following falling edge, so each result is read exactly one rising edge after its cause. For the same-cycle cases (write plus pin read, both read strobes), the bench asserts the strobes together and reads back the cycle after. It also checks that `rd_data` holds over idle cycles and across writes.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
   typedef enum logic {
      QBP_PULLUP     = 1'b0,
      QBP_OPEN_DRAIN = 1'b1
   } qbp_style_e;
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q
);
   localparam logic [WIDTH-1:0] RESET_VAL = {WIDTH{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= RESET_VAL;
      else if (wr_en) latch_q <= wr_data;
   end
endmodule

// File: rtl/qbp_pin_cell.sv
module qbp_pin_cell #(
   parameter qbp_pkg::qbp_style_e STYLE = qbp_pkg::QBP_PULLUP
) (
   input  logic latch_bit,
   input  logic alt_bit,
   input  logic ext_en,
   input  logic ext_val,
   output logic pull_low,
   output logic level,
   output logic floating
);
   logic released;

   assign released = latch_bit & alt_bit;
   assign pull_low = ~released;

   if (STYLE == qbp_pkg::QBP_PULLUP) begin : g_pullup
      // released and undriven: internal pull-up holds the pin high
      assign level    = released & (ext_en ? ext_val : 1'b1);
      assign floating = 1'b0;
   end else begin : g_open_drain
      // released and undriven: nothing holds the pin, flag it
      assign level    = released & ext_en & ext_val;
      assign floating = released & ~ext_en;
   end
endmodule

// File: rtl/qbp_read_path.sv
module qbp_read_path #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_pin_en,
   input  logic             rd_latch_en,
   input  logic [WIDTH-1:0] pin_lvl,
   input  logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rd_data <= '0;
      else if (rd_latch_en) rd_data <= latch_q;
      else if (rd_pin_en)   rd_data <= pin_lvl;
   end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
   parameter int                  WIDTH = 8,
   parameter qbp_pkg::qbp_style_e STYLE = qbp_pkg::QBP_PULLUP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_pin_en,
   input  logic             rd_latch_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] ext_en,
   input  logic [WIDTH-1:0] ext_val,
   output logic [WIDTH-1:0] pull_low,
   output logic [WIDTH-1:0] pin_float
);
   localparam int MAX_WIDTH = 64;

   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("qbp_port: WIDTH must lie in 1..%0d", MAX_WIDTH);
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_lvl;

   qbp_latch #(.WIDTH(WIDTH)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .latch_q (latch_q)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      qbp_pin_cell #(.STYLE(STYLE)) u_cell (
         .latch_bit (latch_q[b]),
         .alt_bit   (alt_out[b]),
         .ext_en    (ext_en[b]),
         .ext_val   (ext_val[b]),
         .pull_low  (pull_low[b]),
         .level     (pin_lvl[b]),
         .floating  (pin_float[b])
      );
   end

   qbp_read_path #(.WIDTH(WIDTH)) u_read (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_pin_en   (rd_pin_en),
      .rd_latch_en (rd_latch_en),
      .pin_lvl     (pin_lvl),
      .latch_q     (latch_q),
      .rd_data     (rd_data)
   );
endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic             rd_pin_en,
   input logic             rd_latch_en,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] latch_q,
   input logic [WIDTH-1:0] pin_lvl,
   input logic [WIDTH-1:0] pull_low,
   input logic [WIDTH-1:0] pin_float
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (latch_q == {WIDTH{1'b1}}));

   assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (latch_q == $past(wr_data)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(latch_q));

   assert_latch_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch_en |=> (rd_data == $past(latch_q)));

   assert_pin_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pin_en && !rd_latch_en) |=> (rd_data == $past(pin_lvl)));

   assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));

   always @(negedge clk) begin
      if (rst_n) begin
         assert_low_wins_R4: assert ((~latch_q & pin_lvl) == '0);
         assert_no_float_low_R6: assert ((pin_float & pull_low) == '0);
      end
   end
endmodule

bind qbp_port qbp_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_pin_en   (rd_pin_en),
   .rd_latch_en (rd_latch_en),
   .rd_data     (rd_data),
   .latch_q     (latch_q),
   .pin_lvl     (pin_lvl),
   .pull_low    (pull_low),
   .pin_float   (pin_float)
);

// File: tb/qbp_port_bench.sv
`timescale 1ns/1ps
module qbp_port_bench;
   localparam int W = 8;
   localparam int NVEC = 6;
   // each entry: {wr_data, alt_out, ext_en, ext_val}
   localparam logic [31:0] VEC [NVEC] = '{
      32'hFF_FF_00_00, 32'hFF_FF_FF_5A, 32'h0F_FF_FF_FF,
      32'hF0_FF_0F_00, 32'hFF_3C_FF_FF, 32'hA5_FF_F0_C0 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_pin_en = 1'b0, rd_latch_en = 1'b0;
   logic [W-1:0] wr_data = '0, alt_out = '1, ext_en = '0, ext_val = '0;
   logic [W-1:0] rd_pu, pl_pu, fl_pu, rd_od, pl_od, fl_od;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qbp_port #(.WIDTH(W), .STYLE(qbp_pkg::QBP_PULLUP)) u_qbp_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_pu),
      .alt_out(alt_out), .ext_en(ext_en), .ext_val(ext_val),
      .pull_low(pl_pu), .pin_float(fl_pu));

   qbp_port #(.WIDTH(W), .STYLE(qbp_pkg::QBP_OPEN_DRAIN)) u_qbp_port_od (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_od),
      .alt_out(alt_out), .ext_en(ext_en), .ext_val(ext_val),
      .pull_low(pl_od), .pin_float(fl_od));

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // one clock: drive on falling edge, results visible on the next falling edge
   task automatic step(logic we, logic [W-1:0] wd, logic rp, logic rl);
      wr_en = we; wr_data = wd; rd_pin_en = rp; rd_latch_en = rl;
      @(negedge clk);
      wr_en = 1'b0; rd_pin_en = 1'b0; rd_latch_en = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] last;
      @(negedge clk); @(negedge clk);
      // R1 during and after reset
      chk("R1 pull_low in reset", pl_pu, 8'h00);
      chk("R1 rd_data in reset", rd_pu, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R1 latch after reset", rd_pu, 8'hFF);

      for (int i = 0; i < NVEC; i++) begin
         logic [W-1:0] wd, al, en, vl, rel, e_pu, e_od, fm;
         {wd, al, en, vl} = VEC[i];
         alt_out = al; ext_en = en; ext_val = vl;
         step(1'b1, wd, 1'b0, 1'b0);
         rel  = wd & al;
         e_pu = rel & ((en & vl) | ~en);
         e_od = rel & en & vl;
         fm   = rel & ~en;
         chk("R8 pull_low matches latch and alt", pl_pu, ~rel);
         chk("R4 pull_low open-drain", pl_od, ~rel);
         step(1'b0, 8'h00, 1'b1, 1'b0);
         chk("R3 R5 pulled-up pin read", rd_pu, e_pu);
         chk("R6 open-drain pin read", rd_od & ~fm, e_od & ~fm);
         chk("R6 open-drain float flags", fl_od, fm);
         chk("R5 no float in pulled-up", fl_pu, 8'h00);
         step(1'b0, 8'h00, 1'b0, 1'b1);
         chk("R7 latch read", rd_pu, wd);
      end

      // R4: latch 0 with external driving high
      alt_out = '1; ext_en = '1; ext_val = '1;
      step(1'b1, 8'h00, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R4 low latch beats external high", rd_pu, 8'h00);
      chk("R4 low latch open-drain", rd_od, 8'h00);

      // R7: latch read ignores pins
      step(1'b1, 8'h96, 1'b0, 1'b0);
      ext_val = 8'h00;
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R7 latch read with pins low", rd_pu, 8'h96);

      // R2: write leaves rd_data alone; R11 hold over idle
      last = rd_pu;
      step(1'b1, 8'h3C, 1'b0, 1'b0);
      chk("R2 write does not touch rd_data", rd_pu, last);
      @(negedge clk); @(negedge clk);
      chk("R11 rd_data held while idle", rd_pu, last);

      // R10: pin read with write in same cycle sees old latch
      ext_en = '0;
      step(1'b1, 8'hFF, 1'b0, 1'b0);
      step(1'b1, 8'h00, 1'b1, 1'b0);
      chk("R10 pin read sees pre-write latch", rd_pu, 8'hFF);
      chk("R2 write took effect", pl_pu, 8'hFF);

      // R9: both strobes, latch wins
      step(1'b1, 8'h5A, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b1);
      chk("R9 latch read wins over pin read", rd_pu, 8'h5A);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule